// File: doc/BRIEF.md
# BCD Watchdog Countdown Timer

This block is a watchdog that counts down in hundredths of a second. The host programs the timeout as four BCD digits held in two byte registers: one for hundredths and one for whole seconds. The longest timeout is 99.99 s. A 100 Hz tick, produced elsewhere from the crystal, moves the count down by one hundredth, with BCD borrow across all four digits. Any host write to either timeout register reloads the count from both registers. This is the host's kick, and it restarts the countdown.

When the count runs out while the watchdog is enabled, the block raises its expired flag. A steering bit then selects what else happens. The block either asserts an interrupt request, which stays up until the host reads the status register, or it drives a fixed-width reset pulse. The count then reloads on its own, so a host that stops kicking sees an expiry every timeout period. A timeout of 00.00 keeps the timer idle whatever the enable bit says.

Top module: `bcd_wdt`

## Requirements
- R1: After a synchronous active-low reset, irq_o, wd_rst_o and flag_o are 0, and every register reads back as 0x00.
- R2: Register map. Offset 0xC holds the hundredths timeout and 0xD holds the seconds timeout, each as two BCD digits. At 0xF, bit 1 is enable and bit 0 is steer (1 = reset pulse, 0 = interrupt). At 0xE, bit 1 is the expired flag and bit 0 is the pending interrupt. Reads return the addressed value combinationally in the same cycle. Any other offset reads 0x00.
- R3: With enable set and a timeout of N (the decimal value of the four BCD digits), expiry happens on the N-th tick after the last timeout write, counting down with BCD borrow. flag_o rises in the clock after that tick.
- R4: In interrupt mode (steer = 0), an expiry sets irq_o together with flag_o, and irq_o stays high until the status register is read.
- R5: In reset mode (steer = 1), an expiry drives wd_rst_o high for exactly PULSE_CLKS clocks (4 by default) and sets flag_o, while irq_o stays low.
- R6: A write to 0xC or 0xD reloads the count from both timeout registers, including the byte being written, and restarts the countdown. A tick in the same cycle as that write is dropped.
- R7: After an expiry the count reloads from the timeout registers, so with no kicks expiries repeat every N ticks.
- R8: With a timeout of 00.00 loaded, no expiry ever occurs, even with enable set.
- R9: While enable is 0, ticks are ignored and the remaining count is held. Setting enable again resumes the count from where it stopped.
- R10: A read of the status register clears flag_o and irq_o at that clock edge. An expiry in the same cycle wins, and both are then set.
- R11: An expiry while a reset pulse is still running is ignored. The pulse is not extended, and no second pulse is started from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-clock strobe at 100 Hz |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (read of status clears it) |
| addr_i | input | ADDR_W | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request, level, held until status read |
| wd_rst_o | output | 1 | Reset pulse, PULSE_CLKS clocks wide |
| flag_o | output | 1 | Watchdog expired flag |

## Verification
The hardest case to reach from the ports is the collision of events on a single edge. A kick can land on the same clock as a tick, a status read can land on the clock of an expiry, and an expiry can fall inside a running reset pulse. The stimulus lines these up by driving tick_i together with a write or a read in the same cycle. It also drives a 00.01 timeout with ticks every second clock, which forces expiries to arrive faster than the pulse can finish. The 00.01.00 timeout walks a borrow through three digits, and the start cycle of each pulse is predicted by a decimal model of the count.

// File: rtl/wdt_pkg.sv
// Package: shared constants for the BCD watchdog.
// Assumes byte-wide registers. The timeout bytes sit at consecutive
// offsets starting at the hundredths byte.
package wdt_pkg;
    localparam int WDT_LOAD_BYTES = 2;                 // hundredths, seconds
    localparam int WDT_DIGITS     = 2 * WDT_LOAD_BYTES; // BCD digits in count
    localparam int OFS_LOAD_BASE  = 'hC;               // hundredths byte
    localparam int OFS_STAT       = 'hE;
    localparam int OFS_CTRL       = 'hF;
    localparam int CTRL_EN_BIT    = 1;
    localparam int CTRL_STEER_BIT = 0;
    localparam int STAT_FLAG_BIT  = 1;
    localparam int STAT_IRQ_BIT   = 0;
endpackage

// File: rtl/wdt_bcd_down.sv
// Module: wdt_bcd_down
// Multi-digit BCD down-counter with reload. Assumes the loaded digits are
// valid BCD. A zero count is idle. Expiry is the tick that would take the
// count from one to zero, and that tick reloads the count instead.
module wdt_bcd_down #(
    parameter int DIGITS = 4,
    localparam int CW    = 4 * DIGITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] reload_val,
    input  logic          tick,
    input  logic          en,
    output logic [CW-1:0] count,
    output logic          expire
);
    logic [CW-1:0]   cnt_q;
    logic [CW-1:0]   dec_val;
    logic [DIGITS:0] borrow;
    logic [DIGITS-1:0] dig_zero;
    logic            cnt_zero;
    logic            cnt_one;

    assign borrow[0] = 1'b1;

    // One stage per digit: decrement when borrowed into, pass borrow on 0.
    for (genvar d = 0; d < DIGITS; d++) begin : g_dig
        logic [3:0] dig;
        assign dig          = cnt_q[4*d +: 4];
        assign dig_zero[d]  = (dig == 4'd0);
        assign borrow[d+1]  = borrow[d] & dig_zero[d];
        assign dec_val[4*d +: 4] = !borrow[d] ? dig
                                 : (dig_zero[d] ? 4'd9 : dig - 4'd1);
    end

    assign cnt_zero = &dig_zero;
    assign cnt_one  = (cnt_q[3:0] == 4'd1) && (&dig_zero[DIGITS-1:1]);
    assign expire   = tick && en && !load && cnt_one;
    assign count    = cnt_q;

    // Count register: kick load first, then reload on expiry, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick && en && !cnt_zero)
            cnt_q <= cnt_one ? reload_val : dec_val;
    end
endmodule

// File: rtl/wdt_pulse.sv
// Module: wdt_pulse
// Fixed-width pulse stretcher. Assumes PULSE_CLKS >= 1. A trigger that
// arrives while a pulse is still running is ignored.
module wdt_pulse #(
    parameter int PULSE_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    localparam int PW = $clog2(PULSE_CLKS + 1);
    localparam logic [PW-1:0] PLOAD = PW'(PULSE_CLKS);

    logic [PW-1:0] left_q;

    // Remaining high cycles: arm from idle, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (trig && left_q == '0)
            left_q <= PLOAD;
        else if (left_q != '0)
            left_q <= left_q - PW'(1);
    end

    assign pulse = (left_q != '0);
endmodule

// File: rtl/wdt_regs.sv
// Module: wdt_regs
// Host register file: the timeout bytes, control and status.
// Assumes single-cycle strobes. Reads are combinational.
// load_next merges the byte being written, so that a kick loads the new value.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int LOAD_BYTES = WDT_LOAD_BYTES,
    localparam int LW        = 8 * LOAD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              expire,
    output logic [LW-1:0]     load_q,
    output logic [LW-1:0]     load_next,
    output logic              kick,
    output logic              ctrl_en,
    output logic              ctrl_steer,
    output logic              flag,
    output logic              irq,
    output logic              rd_stat,
    output logic [7:0]        rdata
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

    logic [LOAD_BYTES-1:0] hit_vec;
    logic en_q, steer_q, flag_q, irq_q;

    // One timeout byte register per load offset.
    for (genvar i = 0; i < LOAD_BYTES; i++) begin : g_load
        localparam logic [ADDR_W-1:0] A_I = ADDR_W'(OFS_LOAD_BASE + i);
        logic [7:0] byte_q;
        assign hit_vec[i] = wr_en && (addr == A_I);
        // Byte store on host write.
        always_ff @(posedge clk) begin
            if (!rst_n)          byte_q <= '0;
            else if (hit_vec[i]) byte_q <= wdata;
        end
        assign load_q[8*i +: 8]    = byte_q;
        assign load_next[8*i +: 8] = hit_vec[i] ? wdata : byte_q;
    end

    assign kick    = |hit_vec;
    assign rd_stat = rd_en && (addr == A_STAT);

    // Control bits: enable and steer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            steer_q <= 1'b0;
        end else if (wr_en && addr == A_CTRL) begin
            en_q    <= wdata[CTRL_EN_BIT];
            steer_q <= wdata[CTRL_STEER_BIT];
        end
    end

    // Status: expiry sets the flags, a status read clears them, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
            if (!steer_q) irq_q <= 1'b1;
        end else if (rd_stat) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < LOAD_BYTES; i++)
            if (addr == ADDR_W'(OFS_LOAD_BASE + i))
                rdata = load_q[8*i +: 8];
        if (addr == A_STAT) begin
            rdata[STAT_FLAG_BIT] = flag_q;
            rdata[STAT_IRQ_BIT]  = irq_q;
        end
        if (addr == A_CTRL) begin
            rdata[CTRL_EN_BIT]    = en_q;
            rdata[CTRL_STEER_BIT] = steer_q;
        end
    end

    assign ctrl_en    = en_q;
    assign ctrl_steer = steer_q;
    assign flag       = flag_q;
    assign irq        = irq_q;
endmodule

// File: rtl/bcd_wdt.sv
// Module: bcd_wdt (top)
// BCD watchdog: the register file, the four-digit countdown and the reset
// pulse. Assumes tick_i is a one-clock strobe at 100 Hz from the clock domain.
module bcd_wdt
    import wdt_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int PULSE_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic              irq_o,
    output logic              wd_rst_o,
    output logic              flag_o
);
    localparam int CW = 4 * WDT_DIGITS;

    logic [CW-1:0] load_q, load_next, count;
    logic kick, ctrl_en, ctrl_steer, expire, rd_stat, load_zero;

    wdt_regs #(.ADDR_W(ADDR_W), .LOAD_BYTES(WDT_LOAD_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .rd_en(rd_en_i),
        .addr(addr_i), .wdata(wdata_i), .expire(expire),
        .load_q(load_q), .load_next(load_next), .kick(kick),
        .ctrl_en(ctrl_en), .ctrl_steer(ctrl_steer), .flag(flag_o),
        .irq(irq_o), .rd_stat(rd_stat), .rdata(rdata_o)
    );

    wdt_bcd_down #(.DIGITS(WDT_DIGITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(kick), .load_val(load_next),
        .reload_val(load_q), .tick(tick_i), .en(ctrl_en),
        .count(count), .expire(expire)
    );

    wdt_pulse #(.PULSE_CLKS(PULSE_CLKS)) u_pulse (
        .clk(clk), .rst_n(rst_n), .trig(expire && ctrl_steer),
        .pulse(wd_rst_o)
    );

    assign load_zero = (load_q == '0);
endmodule

// File: rtl/wdt_chk.sv
// Module: wdt_chk
// Property checker for bcd_wdt, attached with the bind statement below.
module wdt_chk #(
    parameter int PULSE_CLKS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic expire,
    input logic steer,
    input logic load_zero,
    input logic rd_stat,
    input logic wd_rst,
    input logic irq,
    input logic flag
);
    localparam int LEN_W = $clog2(PULSE_CLKS + 2) + 1;
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(PULSE_CLKS);

    logic [LEN_W-1:0] hi_len;

    // Length of the current high run of the reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_len <= '0;
        else if (wd_rst) hi_len <= hi_len + LEN_W'(1);
        else             hi_len <= '0;
    end

    a_r3_expire_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);
    a_r4_irq_only_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !$past(steer));
    a_r4_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_stat) |=> irq);
    a_r5_rst_only_rst_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst) |-> $past(steer));
    a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst) |-> (hi_len == LEN_MAX));
    a_r11_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        hi_len <= LEN_MAX);
    a_r8_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        load_zero |-> !expire);
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !expire) |=> (!flag && !irq));
endmodule

bind bcd_wdt wdt_chk #(.PULSE_CLKS(PULSE_CLKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .expire(expire), .steer(ctrl_steer),
    .load_zero(load_zero), .rd_stat(rd_stat), .wd_rst(wd_rst_o),
    .irq(irq_o), .flag(flag_o)
);

// File: tb/bcd_wdt_tb.sv
`timescale 1ns/1ps
module bcd_wdt_tb;
    localparam int ADDR_W = 5;
    localparam int PCLK   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic irq, wd_rst, flag;

    int n_checks = 0, n_fail = 0;
    int cyc = 0;
    int sb_q[$];
    bit sb_on = 1'b0;
    int free_pulses = 0;
    bit done = 1'b0;

    // Decimal model of the timer.
    int m_hund = 0, m_sec = 0, m_cnt = 0;
    bit m_en = 1'b0, m_steer = 1'b0;

    bcd_wdt #(.ADDR_W(ADDR_W), .PULSE_CLKS(PCLK)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
        .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .irq_o(irq), .wd_rst_o(wd_rst), .flag_o(flag)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int bcd2int(int b);
        return 10 * ((b >> 4) & 15) + (b & 15);
    endfunction

    function automatic int m_load();
        return 100 * bcd2int(m_sec) + bcd2int(m_hund);
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Model one tick (driver side); pushes the expected pulse start cycle.
    task automatic m_tick();
        if (m_en && m_cnt > 0) begin
            if (m_cnt == 1) begin
                m_cnt = m_load();
                if (m_steer && sb_on) sb_q.push_back(cyc + 1);
            end else m_cnt--;
        end
    endtask

    task automatic m_write(input int a, input int d);
        if (a == 'hC) m_hund = d;
        if (a == 'hD) m_sec = d;
        if (a == 'hF) begin m_en = d[1]; m_steer = d[0]; end
        if (a == 'hC || a == 'hD) m_cnt = m_load();
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = 8'(d);
        m_write(a, d);
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Write a timeout byte and tick in the same cycle (kick wins).
    task automatic wr_tick(input int a, input int d);
        wr_en = 1'b1; tick = 1'b1; addr = ADDR_W'(a); wdata = 8'(d);
        m_write(a, d);
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string tag);
        rd_en = 1'b1; addr = ADDR_W'(a);
        #1 chk(rdata, exp, tag);
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Status read in the same cycle as a tick.
    task automatic rd_tick_chk(input int exp, input string tag);
        rd_en = 1'b1; tick = 1'b1; addr = ADDR_W'('hE);
        m_tick();
        #1 chk(rdata, exp, tag);
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0; tick = 1'b0;
    endtask

    task automatic ticks(input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            m_tick();
            @(posedge clk); @(negedge clk);
            tick = 1'b0;
            for (int g = 1; g < gap; g++) @(negedge clk);
        end
    endtask

    // Monitor: pulse starts against the scoreboard, and every pulse width.
    int hi_run = 0;
    bit prev_rst = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (wd_rst && !prev_rst) begin
                if (sb_on) begin
                    if (sb_q.size() == 0) chk(cyc, -1, "R5 unexpected pulse");
                    else chk(cyc, sb_q.pop_front(), "R3 pulse start cycle");
                end else free_pulses++;
            end
            if (wd_rst) hi_run++;
            else if (prev_rst) begin
                chk(hi_run, PCLK, "R5 R11 pulse width");
                hi_run = 0;
            end
            prev_rst = wd_rst;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(irq, 0, "R1 irq"); chk(wd_rst, 0, "R1 rst"); chk(flag, 0, "R1 flag");
        rd_chk('hC, 0, "R1 hund"); rd_chk('hD, 0, "R1 sec");
        rd_chk('hF, 0, "R1 ctrl"); rd_chk('hE, 0, "R1 stat");

        // R2 map and readback, interrupt mode
        wr('hF, 'h02); wr('hD, 'h00); wr('hC, 'h12);
        rd_chk('hC, 'h12, "R2 hund"); rd_chk('hD, 'h00, "R2 sec");
        rd_chk('hF, 'h02, "R2 ctrl"); rd_chk('h3, 'h00, "R2 unused");

        // R3 R4 countdown with borrow to expiry at 12 ticks
        ticks(11, 2);
        chk(flag, 0, "R3 no early flag"); chk(irq, 0, "R4 no early irq");
        ticks(1, 2);
        chk(flag, 1, "R3 flag"); chk(irq, 1, "R4 irq");
        ticks(3, 2);
        chk(irq, 1, "R4 irq held");
        // R7 periodic reload: 9 more ticks make 12 since the expiry
        rd_chk('hE, 'h03, "R2 R4 stat");
        chk(flag, 0, "R10 flag cleared"); chk(irq, 0, "R10 irq cleared");
        ticks(8, 2);
        chk(irq, 0, "R7 not yet");
        ticks(1, 2);
        chk(irq, 1, "R7 periodic irq");
        rd_chk('hE, 'h03, "R7 stat");

        // R6 kick restarts, and kick wins over a tick in the same cycle
        ticks(8, 2);
        wr_tick('hC, 'h12);
        ticks(11, 2);
        chk(irq, 0, "R6 kick restarted");
        ticks(1, 2);
        chk(irq, 1, "R6 expiry after kick");
        rd_chk('hE, 'h03, "R6 stat");

        // R9 disable holds the count
        ticks(5, 2);
        wr('hF, 'h00);
        ticks(20, 2);
        chk(irq, 0, "R9 disabled"); chk(flag, 0, "R9 flag");
        wr('hF, 'h02);
        ticks(6, 2);
        chk(irq, 0, "R9 resumed not yet");
        ticks(1, 2);
        chk(irq, 1, "R9 resumed expiry");
        rd_chk('hE, 'h03, "R9 stat");

        // R10 status read in the expiry cycle: set wins
        ticks(11, 2);
        rd_tick_chk('h00, "R10 read before set");
        chk(flag, 1, "R10 set wins flag"); chk(irq, 1, "R10 set wins irq");
        rd_chk('hE, 'h03, "R10 stat");
        chk(flag, 0, "R10 cleared");

        // R5 reset mode, 01.00 = 100 ticks, scoreboard on
        sb_on = 1'b1;
        wr('hF, 'h03); wr('hD, 'h01); wr('hC, 'h00);
        ticks(99, 8);
        chk(flag, 0, "R3 borrow no early");
        ticks(1, 8);
        chk(flag, 1, "R5 flag"); chk(irq, 0, "R5 no irq");
        ticks(100, 8);
        chk(sb_q.size(), 0, "R7 all pulses seen");
        rd_chk('hE, 'h02, "R5 stat");

        // R8 zero timeout is idle
        wr('hC, 'h00); wr('hD, 'h00);
        ticks(30, 8);
        chk(flag, 0, "R8 idle flag"); chk(sb_q.size(), 0, "R8 no pulse");

        // R11 expiries during a running pulse are ignored
        sb_on = 1'b0;
        wr('hC, 'h01);
        ticks(12, 2);
        repeat (8) @(negedge clk);
        chk(free_pulses, 4, "R11 pulse count");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule